// File: doc/BRIEF.md
# Overcurrent Fault Latch with Timed Retry

This block decides whether a motor bridge may conduct. It follows an overcurrent detect, a thermal comparator and a supply-low flag, and it produces a bridge-disable line and an active-low fault indication. An overcurrent trips the fault. The mode input, read at the moment of the trip, then selects one of two recovery paths. In automatic mode the bridge is held off for a fixed timeout and then enabled again for a short trial window. If no overcurrent appears during that window, the fault clears. In locked mode the bridge stays off until a standby-exit pulse arrives or the block is reset.

Thermal shutdown and supply undervoltage disable the bridge directly. The hysteresis of the temperature comparison is applied outside the block. Neither condition is reported on the fault output, which belongs to overcurrent events alone. All inputs are sampled on the rising clock edge, and both outputs come from registers.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: While rst_n is low, bridge_off is 1 and fault_n is 1. Reset discards any fault state. In the first cycle after a clock edge with rst_n high, bridge_off reflects only thermal_hot and uv_low.
- R2: With no fault pending (fault_n = 1), an oc_detect sampled high makes bridge_off 1 and fault_n 0 from the next cycle on.
- R3: If retry_auto is 1 when an overcurrent is taken, bridge_off stays 1 for exactly RETRY_CYCLES cycles and then drops to 0. fault_n stays 0 for that whole time.
- R4: After the holdoff, the bridge is enabled for a trial window of PROBE_CYCLES cycles with fault_n still 0. If oc_detect stays low throughout, fault_n returns to 1 in the cycle after the window ends.
- R5: An oc_detect sampled high during the trial window re-reads retry_auto. With retry_auto = 1, the bridge is disabled again from the next cycle and a full RETRY_CYCLES holdoff restarts. With retry_auto = 0, the fault locks.
- R6: If retry_auto is 0 when an overcurrent is taken, bridge_off = 1 and fault_n = 0 are held indefinitely. Further oc_detect pulses and changes of retry_auto have no effect while the fault is held.
- R7: A standby_exit pulse sampled high while a fault is pending clears it. In the next cycle fault_n is 1 and the bridge is enabled, apart from thermal or undervoltage conditions. This applies to a locked fault, a holdoff and a trial window alike.
- R8: oc_detect pulses during the holdoff are ignored. The holdoff still ends exactly RETRY_CYCLES cycles after the original trip.
- R9: thermal_hot or uv_low sampled high forces bridge_off to 1 from the next cycle, for as long as either is held, in any fault state.
- R10: thermal_hot and uv_low never drive fault_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| oc_detect | input | 1 | Overcurrent detected, active high |
| retry_auto | input | 1 | 1 = automatic retry after timeout, 0 = locked fault |
| standby_exit | input | 1 | One-cycle pulse on leaving low-power standby |
| thermal_hot | input | 1 | Thermal shutdown request, hysteresis applied externally |
| uv_low | input | 1 | Supply below undervoltage threshold |
| bridge_off | output | 1 | 1 = all bridge drivers disabled |
| fault_n | output | 1 | Overcurrent fault indication, active low |

## Verification
The bench builds the block with RETRY_CYCLES = 8 and PROBE_CYCLES = 4. These short windows let every holdoff and trial cycle be checked one by one, rather than only at the window edges. They also let an overcurrent be placed at every offset of the trial window and a pulse be injected inside the holdoff. All four combinations of thermal and undervoltage input are swept in the idle state. Long locked periods, stimulated with toggled overcurrent and mode inputs, run in a few dozen cycles.

// File: rtl/ocp_pkg.sv
// Package: shared state encoding for the overcurrent fault controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package ocp_pkg;
    typedef enum logic [1:0] {
        OCP_CLEAR   = 2'd0, // no fault, bridge allowed
        OCP_HOLDOFF = 2'd1, // retry timeout running, bridge off
        OCP_TRIAL   = 2'd2, // bridge re-enabled, watching for overcurrent
        OCP_LOCKED  = 2'd3  // fault held until standby exit or reset
    } ocp_state_e;
endpackage

// File: rtl/ocp_window_timer.sv
// Module: counts the holdoff or the trial window and flags its last cycle.
// Assumes: both window lengths are at least 2; clear is pulsed on every
// state change so a window always starts from zero.
module ocp_window_timer #(
    parameter int RETRY_CYCLES = 200000,
    parameter int PROBE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sel_probe,
    output logic done
);
    localparam int MAX_LEN = (RETRY_CYCLES > PROBE_CYCLES) ? RETRY_CYCLES : PROBE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROBE_LAST = CNT_W'(PROBE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_w;

    // Pick the terminal count of the active window.
    always_comb begin
        last_w = sel_probe ? PROBE_LAST : RETRY_LAST;
        done   = (cnt_q == last_w);
    end

    // Count up from zero after a clear; hold at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_fault_fsm.sv
// Module: overcurrent fault sequencing (trip, holdoff, trial, lock, clear).
// Assumes: the mode input is read only when an overcurrent is taken;
// a standby exit clears any pending fault but never blocks a new trip
// from the clear state.
module ocp_fault_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               oc_detect,
    input  logic               retry_auto,
    input  logic               standby_exit,
    input  logic               tmr_done,
    output ocp_pkg::ocp_state_e state,
    output logic               tmr_clear,
    output logic               tmr_sel_probe
);
    import ocp_pkg::*;

    ocp_state_e state_q;
    ocp_state_e state_nxt;
    ocp_state_e trip_dest;

    // Destination of a newly taken overcurrent, chosen by the mode input.
    always_comb begin
        trip_dest = retry_auto ? OCP_HOLDOFF : OCP_LOCKED;
    end

    // Next-state decision for every fault state.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            OCP_CLEAR: begin
                if (oc_detect) state_nxt = trip_dest;
            end
            OCP_HOLDOFF: begin
                if (standby_exit)  state_nxt = OCP_CLEAR;
                else if (tmr_done) state_nxt = OCP_TRIAL;
            end
            OCP_TRIAL: begin
                if (standby_exit)   state_nxt = OCP_CLEAR;
                else if (oc_detect) state_nxt = trip_dest;
                else if (tmr_done)  state_nxt = OCP_CLEAR;
            end
            OCP_LOCKED: begin
                if (standby_exit) state_nxt = OCP_CLEAR;
            end
            default: state_nxt = OCP_CLEAR;
        endcase
    end

    // State register; power-on reset returns to the clear state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCP_CLEAR;
        else        state_q <= state_nxt;
    end

    // Timer control: restart on each transition, window chosen by state.
    always_comb begin
        tmr_clear     = (state_nxt != state_q);
        tmr_sel_probe = (state_q == OCP_TRIAL);
        state         = state_q;
    end
endmodule

// File: rtl/ocp_output_gate.sv
// Module: merges fault state with thermal and undervoltage conditions into
// the bridge-disable and fault outputs.
// Assumes: thermal_hot already carries its hysteresis; the environmental
// flags are registered once and come up asserted out of reset.
module ocp_output_gate (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               thermal_hot,
    input  logic               uv_low,
    input  ocp_pkg::ocp_state_e state,
    output logic               bridge_off,
    output logic               fault_n
);
    import ocp_pkg::*;

    logic env_off_q;

    // Register the environmental shutdown request; safe-off during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) env_off_q <= 1'b1;
        else        env_off_q <= thermal_hot | uv_low;
    end

    // Decode outputs from the registered state and environment flag.
    always_comb begin
        bridge_off = env_off_q
                   | (state == OCP_HOLDOFF)
                   | (state == OCP_LOCKED);
        fault_n    = (state == OCP_CLEAR);
    end
endmodule

// File: rtl/ocp_fault_ctrl.sv
// Module: top of the overcurrent fault controller with timed retry.
// Assumes: one clock domain; all inputs synchronous to clk; RETRY_CYCLES
// and PROBE_CYCLES are cycle counts of the holdoff and trial window.
module ocp_fault_ctrl #(
    parameter int RETRY_CYCLES = 200000,
    parameter int PROBE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_detect,
    input  logic retry_auto,
    input  logic standby_exit,
    input  logic thermal_hot,
    input  logic uv_low,
    output logic bridge_off,
    output logic fault_n
);
    ocp_pkg::ocp_state_e fsm_state;
    logic tmr_clear;
    logic tmr_sel_probe;
    logic tmr_done;

    ocp_window_timer #(
        .RETRY_CYCLES(RETRY_CYCLES),
        .PROBE_CYCLES(PROBE_CYCLES)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tmr_clear),
        .sel_probe (tmr_sel_probe),
        .done      (tmr_done)
    );

    ocp_fault_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .oc_detect     (oc_detect),
        .retry_auto    (retry_auto),
        .standby_exit  (standby_exit),
        .tmr_done      (tmr_done),
        .state         (fsm_state),
        .tmr_clear     (tmr_clear),
        .tmr_sel_probe (tmr_sel_probe)
    );

    ocp_output_gate gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .thermal_hot (thermal_hot),
        .uv_low      (uv_low),
        .state       (fsm_state),
        .bridge_off  (bridge_off),
        .fault_n     (fault_n)
    );
endmodule

// File: rtl/ocp_fault_ctrl_chk.sv
// Module: property checker bound to the overcurrent fault controller.
// Assumes: observes ports plus the fault state driven by the sequencer.
module ocp_fault_ctrl_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               oc_detect,
    input logic               standby_exit,
    input logic               thermal_hot,
    input logic               uv_low,
    input logic               bridge_off,
    input logic               fault_n,
    input ocp_pkg::ocp_state_e fsm_state
);
    import ocp_pkg::*;

    a_r2_trip_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && oc_detect) |=> (bridge_off && !fault_n));

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == OCP_LOCKED && !standby_exit) |=> (fsm_state == OCP_LOCKED && bridge_off && !fault_n));

    a_r7_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && standby_exit) |=> fault_n);

    a_r9_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_hot |=> bridge_off);

    a_r9_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low |=> bridge_off);

    a_r10_env_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && !oc_detect) |=> fault_n);

    a_r8_holdoff_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == OCP_HOLDOFF) |-> bridge_off);
endmodule

bind ocp_fault_ctrl ocp_fault_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .oc_detect    (oc_detect),
    .standby_exit (standby_exit),
    .thermal_hot  (thermal_hot),
    .uv_low       (uv_low),
    .bridge_off   (bridge_off),
    .fault_n      (fault_n),
    .fsm_state    (fsm_state)
);

// File: tb/ocp_fault_ctrl_tb_top.sv
// Bench: directed near-exhaustive sweeps over a short-window configuration.
module ocp_fault_ctrl_tb_top;
    localparam int R = 8;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_detect = 1'b0;
    logic retry_auto = 1'b1;
    logic standby_exit = 1'b0;
    logic thermal_hot = 1'b0;
    logic uv_low = 1'b0;
    logic bridge_off;
    logic fault_n;

    int vectors = 0;
    int miscompares = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    ocp_fault_ctrl #(.RETRY_CYCLES(R), .PROBE_CYCLES(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .oc_detect(oc_detect), .retry_auto(retry_auto),
        .standby_exit(standby_exit), .thermal_hot(thermal_hot), .uv_low(uv_low),
        .bridge_off(bridge_off), .fault_n(fault_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic eoff, input logic efn);
        vectors++;
        if (bridge_off !== eoff || fault_n !== efn) begin
            miscompares++;
            $display("FAIL %s: bridge_off=%b fault_n=%b expected bridge_off=%b fault_n=%b",
                     req, bridge_off, fault_n, eoff, efn);
        end
    endtask

    // Take an overcurrent from the clear state; afterwards one cycle in.
    task automatic trip(input logic mode);
        retry_auto = mode;
        oc_detect = 1'b1;
        step();
        oc_detect = 1'b0;
    endtask

    // Holdoff: R cycles off with fault low; optional ignored pulse at poke_at.
    task automatic holdoff(input string req, input int poke_at);
        for (int i = 0; i < R; i++) begin
            chk(req, 1'b1, 1'b0);
            if (i == poke_at) oc_detect = 1'b1;
            step();
            oc_detect = 1'b0;
        end
    endtask

    // Trial window: P cycles on with fault low, then clear, or a recurrence.
    task automatic trial(input string req, input int fail_at);
        for (int j = 0; j < P; j++) begin
            chk(req, 1'b0, 1'b0);
            if (j == fail_at) begin
                oc_detect = 1'b1;
                step();
                oc_detect = 1'b0;
                return;
            end
            step();
        end
        chk(req, 1'b0, 1'b1);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done_flag) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        chk("R1 in reset", 1'b1, 1'b1);
        oc_detect = 1'b1;
        step();
        chk("R1 oc ignored in reset", 1'b1, 1'b1);
        oc_detect = 1'b0;
        rst_n = 1'b1;
        step();
        chk("R1 after reset", 1'b0, 1'b1);

        // R9/R10: all environmental combinations in the clear state.
        for (int e = 0; e < 4; e++) begin
            thermal_hot = e[0];
            uv_low = e[1];
            step();
            chk("R9 R10 env sweep", logic'(e[0] | e[1]), 1'b1);
        end
        thermal_hot = 1'b0;
        uv_low = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            chk("R10 uv held", 1'b1, 1'b1);
        end
        uv_low = 1'b0;
        step();
        chk("R9 uv released", 1'b0, 1'b1);

        // R2, R3, R4: clean automatic retry.
        trip(1'b1);
        chk("R2 trip", 1'b1, 1'b0);
        holdoff("R3", -1);
        trial("R4", -1);

        // R5: recurrence at every trial offset restarts the holdoff.
        for (int k = 0; k < P; k++) begin
            trip(1'b1);
            holdoff("R3", -1);
            trial("R5 recur", k);
            holdoff("R5 restart", -1);
            trial("R4 after restart", -1);
        end

        // R8: pulses inside the holdoff do not move its end.
        for (int k = 0; k < R; k += 3) begin
            trip(1'b1);
            holdoff("R8", k);
            trial("R8 then R4", -1);
        end

        // R5: mode switched to locked before a recurrence in the trial.
        trip(1'b1);
        holdoff("R3", -1);
        chk("R5 trial", 1'b0, 1'b0);
        retry_auto = 1'b0;
        oc_detect = 1'b1;
        step();
        oc_detect = 1'b0;
        for (int k = 0; k < 3 * R; k++) begin
            chk("R5 locks", 1'b1, 1'b0);
            step();
        end
        standby_exit = 1'b1;
        step();
        standby_exit = 1'b0;
        chk("R7 lock cleared", 1'b0, 1'b1);

        // R6: locked fault ignores further overcurrent and mode changes.
        trip(1'b0);
        for (int k = 0; k < 3 * R; k++) begin
            chk("R6 held", 1'b1, 1'b0);
            oc_detect = (k % 2 == 0);
            retry_auto = (k % 5 == 0);
            step();
        end
        oc_detect = 1'b0;
        retry_auto = 1'b0;
        chk("R6 held", 1'b1, 1'b0);
        standby_exit = 1'b1;
        step();
        standby_exit = 1'b0;
        chk("R7 standby clears lock", 1'b0, 1'b1);
        step();
        chk("R7 stays clear", 1'b0, 1'b1);

        // R7: standby exit during holdoff and during trial.
        trip(1'b1);
        for (int k = 0; k < 3; k++) begin
            chk("R3", 1'b1, 1'b0);
            step();
        end
        standby_exit = 1'b1;
        step();
        standby_exit = 1'b0;
        chk("R7 holdoff cleared", 1'b0, 1'b1);

        trip(1'b1);
        holdoff("R3", -1);
        chk("R4 trial", 1'b0, 1'b0);
        standby_exit = 1'b1;
        step();
        standby_exit = 1'b0;
        chk("R7 trial cleared", 1'b0, 1'b1);

        // R9/R10: thermal shutdown during a locked fault and in the clear state.
        trip(1'b0);
        thermal_hot = 1'b1;
        step();
        chk("R9 thermal in lock", 1'b1, 1'b0);
        standby_exit = 1'b1;
        step();
        standby_exit = 1'b0;
        chk("R9 thermal after clear", 1'b1, 1'b1);
        thermal_hot = 1'b0;
        step();
        chk("R9 thermal released", 1'b0, 1'b1);

        // R1: reset discards a locked fault.
        trip(1'b0);
        chk("R2 trip locked", 1'b1, 1'b0);
        rst_n = 1'b0;
        step();
        chk("R1 reset in lock", 1'b1, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1 lock discarded", 1'b0, 1'b1);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule